// File: doc/BRIEF.md
# Flash Row Buffer and Timed Program/Erase Sequencer

This block sits between the processor's table-write path and the on-chip flash array. Software fills a holding buffer with one full row: 64 instruction words of 24 bits each. Each word is loaded with one table-write strobe. The loads must start at the first word of a 64-word aligned group and continue in strict ascending order.

A start command selects one of three operations:
- a row program, which streams the whole buffer into the array;
- a single-word program, which writes buffer slot 0 to any address;
- a page erase, which clears the 512-word aligned page that contains the command address.

The operation then lasts a fixed number of ticks of the internal RC oscillator. Each operation type has its own tick count, set by a parameter. The default row count is 11064 ticks, about 1.5 ms at 7.37 MHz. The processor is held on `busy` for the whole timed operation. The end is marked by a one-cycle `done` pulse.

A load that breaks the ordering or alignment rule sets a sticky error flag. A later row-program request is then refused, and the refusal clears the error and the buffer. The analog array itself and the oscillator trimming are outside this block.

Top module: `flash_row_seq`

## Requirements
- R1: After reset `busy`, `done`, `arr_wr`, `arr_erase` and `load_err` are 0, and the buffer is empty.
- R2: A table write while idle is accepted only in two cases. When the buffer is empty, the address must have its low 6 bits equal to zero. Otherwise it must equal the previous load address plus one, within the same 64-word group, and the buffer must hold fewer than 64 words. Any other write, including a 65th write, sets `load_err`, which stays set until a refused row start.
- R3: Table writes while `busy` is high have no effect on the buffer or on `load_err`.
- R4: A row program streams its 64 buffered words to the array in load order: one `arr_wr` per clock, at consecutive addresses starting at the group base.
- R5: A row start (`cmd_op` = 0) with `load_err` set, or with fewer than 64 loaded words, is refused. In the next cycle `done`=1 and `done_ok`=0, `busy` stays 0, and nothing reaches the array. The refusal clears `load_err` and empties the buffer.
- R6: A page erase (`cmd_op` = 2) issues exactly one `arr_erase` with `arr_addr` equal to `cmd_addr` with its low 9 bits cleared.
- R7: A word program (`cmd_op` = 1) issues exactly one `arr_wr` at `cmd_addr`, carrying buffer slot 0. The buffer is left as it was.
- R8: `busy` rises in the cycle after an accepted start. It stays high for exactly ROW_CYC, WORD_CYC or PAGE_CYC cycles in which `rc_tick` is high, and falls together with a one-cycle `done` pulse that has `done_ok`=1.
- R9: After a successful row program the buffer is empty, so the next load must again be at offset 0 of any group.
- R10: A start while `busy` is high is ignored, and `cmd_op` = 3 is ignored at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tw_we | input | 1 | Table-write strobe into the holding buffer |
| tw_addr | input | AW | Instruction word address of the table write |
| tw_data | input | 24 | Instruction word to buffer |
| cmd_start | input | 1 | Start strobe for a program or erase |
| cmd_op | input | 2 | 0 row program, 1 word program, 2 page erase, 3 none |
| cmd_addr | input | AW | Target address for word program and page erase |
| rc_tick | input | 1 | One-cycle enable per internal RC oscillator period |
| arr_wr | output | 1 | Array word write strobe |
| arr_erase | output | 1 | Array page erase strobe |
| arr_addr | output | AW | Array address for write or erase |
| arr_wdata | output | 24 | Array write data |
| busy | output | 1 | Processor stall while an operation runs |
| done | output | 1 | One-cycle end of operation or refusal |
| done_ok | output | 1 | Qualifies `done`: 1 completed, 0 refused |
| load_err | output | 1 | Sticky buffer-load ordering error |

## Verification
On every cycle the assertions check the following:
- `done` is a single pulse and always coincides with the fall of `busy`;
- array strobes appear only while busy and never both at once;
- consecutive row writes step the address by one;
- erase addresses are page aligned;
- a flagged row start ends in a refusal;
- `load_err` clears only through that refusal.

The exact tick count of each operation, the data that lands at each address, and the fact that loads and starts during a busy cycle leave no trace can only be shown by the bench's scenarios. The bench follows this with a model of the array.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam int WORD_W  = 24;
    localparam int ROW_LG  = 6;
    localparam int PAGE_LG = 9;

    typedef enum logic [1:0] {
        OP_ROW  = 2'd0,
        OP_WORD = 2'd1,
        OP_PAGE = 2'd2,
        OP_NONE = 2'd3
    } flash_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/flash_row_loader.sv
module flash_row_loader #(
    parameter int AW     = 12,
    parameter int ROW_LG = 6,
    parameter int DW     = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_we,
    input  logic [AW-1:0]     ld_addr,
    input  logic [DW-1:0]     ld_data,
    input  logic              clr,
    input  logic [ROW_LG-1:0] rd_idx,
    output logic [DW-1:0]     rd_data,
    output logic              full,
    output logic              err,
    output logic [AW-1:0]     base
);
    localparam int ROWS = 1 << ROW_LG;

    logic [DW-1:0]   slots [ROWS];
    logic [ROW_LG:0] fill;
    logic [AW-1:0]   base_q;
    logic            err_q;
    logic            in_seq;
    logic            take;

    // Empty buffer: only a group-aligned address opens a row.
    // Otherwise the next address in the same group is required.
    always_comb begin
        if (fill == '0)
            in_seq = (ld_addr[ROW_LG-1:0] == '0);
        else
            in_seq = !fill[ROW_LG] &&
                     (ld_addr == {base_q[AW-1:ROW_LG], fill[ROW_LG-1:0]});
    end

    assign take = ld_we && !err_q && !clr && in_seq;

    always_ff @(posedge clk) begin
        if (rst) begin
            fill   <= '0;
            base_q <= '0;
            err_q  <= 1'b0;
        end else if (clr) begin
            fill  <= '0;
            err_q <= 1'b0;
        end else if (ld_we && !err_q) begin
            if (in_seq) begin
                fill <= fill + 1'b1;
                if (fill == '0)
                    base_q <= ld_addr;
            end else begin
                err_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (take)
            slots[fill[ROW_LG-1:0]] <= ld_data;
    end

    assign rd_data = slots[rd_idx];
    assign full    = fill[ROW_LG];
    assign err     = err_q;
    assign base    = base_q;

endmodule

// File: rtl/flash_cycle_timer.sv
module flash_cycle_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  logic          run,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          last
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || arm)
            cnt <= '0;
        else if (run && tick)
            cnt <= cnt + 1'b1;
    end

    // High on the tick that completes the requested count.
    assign last = run && tick && (cnt == limit - 1'b1);

endmodule

// File: rtl/flash_row_seq.sv
module flash_row_seq
    import flash_seq_pkg::*;
#(
    parameter int AW       = 12,
    parameter int ROW_CYC  = 11064,
    parameter int WORD_CYC = 400,
    parameter int PAGE_CYC = 11500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tw_we,
    input  logic [AW-1:0]     tw_addr,
    input  logic [WORD_W-1:0] tw_data,
    input  logic              cmd_start,
    input  logic [1:0]        cmd_op,
    input  logic [AW-1:0]     cmd_addr,
    input  logic              rc_tick,
    output logic              arr_wr,
    output logic              arr_erase,
    output logic [AW-1:0]     arr_addr,
    output logic [WORD_W-1:0] arr_wdata,
    output logic              busy,
    output logic              done,
    output logic              done_ok,
    output logic              load_err
);
    localparam int ROWS    = 1 << ROW_LG;
    localparam int MAX_CYC = max3(ROW_CYC, WORD_CYC, PAGE_CYC);
    localparam int CW      = $clog2(MAX_CYC + 1);

    seq_state_e        state;
    flash_op_e         op_q;
    flash_op_e         op_in;
    logic [AW-1:0]     addr_q;
    logic [ROW_LG-1:0] xidx;
    logic              done_q, ok_q;

    logic              buf_full, buf_err, buf_clr;
    logic [AW-1:0]     buf_base;
    logic [WORD_W-1:0] buf_rd;
    logic [CW-1:0]     limit;
    logic              last_tick;
    logic              accept, refuse, go, xfer_end, fin;

    assign op_in  = flash_op_e'(cmd_op);
    assign busy   = (state != ST_IDLE);
    assign accept = cmd_start && !busy && (op_in != OP_NONE);
    assign refuse = accept && (op_in == OP_ROW) && (buf_err || !buf_full);
    assign go     = accept && !refuse;

    always_comb begin
        case (op_q)
            OP_ROW:  limit = CW'(ROW_CYC);
            OP_PAGE: limit = CW'(PAGE_CYC);
            default: limit = CW'(WORD_CYC);
        endcase
    end

    assign xfer_end = (state == ST_XFER) &&
                      ((op_q != OP_ROW) || (xidx == {ROW_LG{1'b1}}));
    assign fin      = last_tick && ((state == ST_WAIT) || xfer_end);
    assign buf_clr  = refuse || (fin && (op_q == OP_ROW));

    flash_row_loader #(
        .AW(AW), .ROW_LG(ROW_LG), .DW(WORD_W)
    ) u_loader (
        .clk    (clk),
        .rst    (rst),
        .ld_we  (tw_we && !busy),
        .ld_addr(tw_addr),
        .ld_data(tw_data),
        .clr    (buf_clr),
        .rd_idx (xidx),
        .rd_data(buf_rd),
        .full   (buf_full),
        .err    (buf_err),
        .base   (buf_base)
    );

    flash_cycle_timer #(
        .CW(CW)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .arm  (go),
        .run  (busy),
        .tick (rc_tick),
        .limit(limit),
        .last (last_tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            op_q   <= OP_NONE;
            addr_q <= '0;
            xidx   <= '0;
            done_q <= 1'b0;
            ok_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            ok_q   <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (refuse) begin
                        done_q <= 1'b1;
                    end else if (go) begin
                        state <= ST_XFER;
                        op_q  <= op_in;
                        xidx  <= '0;
                        case (op_in)
                            OP_ROW:  addr_q <= buf_base;
                            OP_PAGE: addr_q <= (cmd_addr >> PAGE_LG) << PAGE_LG;
                            default: addr_q <= cmd_addr;
                        endcase
                    end
                end
                ST_XFER: begin
                    if (fin) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                        ok_q   <= 1'b1;
                    end else if (xfer_end) begin
                        state <= ST_WAIT;
                    end else begin
                        xidx <= xidx + 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (fin) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                        ok_q   <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign arr_wr    = (state == ST_XFER) && (op_q != OP_PAGE);
    assign arr_erase = (state == ST_XFER) && (op_q == OP_PAGE);
    assign arr_addr  = addr_q | {{(AW-ROW_LG){1'b0}}, xidx};
    assign arr_wdata = buf_rd;
    assign done      = done_q;
    assign done_ok   = ok_q;
    assign load_err  = buf_err;

endmodule

// File: rtl/flash_row_seq_chk.sv
module flash_row_seq_chk #(
    parameter int AW      = 12,
    parameter int PAGE_LG = 9
) (
    input logic          clk,
    input logic          rst,
    input logic          cmd_start,
    input logic [1:0]    cmd_op,
    input logic          arr_wr,
    input logic          arr_erase,
    input logic [AW-1:0] arr_addr,
    input logic          busy,
    input logic          done,
    input logic          done_ok,
    input logic          load_err
);
    localparam logic [AW-1:0] PAGE_MASK = AW'((1 << PAGE_LG) - 1);

    a_r8_fall_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done && done_ok));

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r4_strobe_busy: assert property (@(posedge clk) disable iff (rst)
        (arr_wr || arr_erase) |-> busy);

    a_r4_no_both: assert property (@(posedge clk) disable iff (rst)
        !(arr_wr && arr_erase));

    a_r4_row_step: assert property (@(posedge clk) disable iff (rst)
        (arr_wr && $past(arr_wr)) |-> (arr_addr == $past(arr_addr) + 1'b1));

    a_r6_erase_aligned: assert property (@(posedge clk) disable iff (rst)
        arr_erase |-> ((arr_addr & PAGE_MASK) == '0));

    a_r5_refuse: assert property (@(posedge clk) disable iff (rst)
        (cmd_start && !busy && cmd_op == 2'd0 && load_err) |=> (done && !done_ok && !busy));

    a_r2_err_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(load_err) |-> (done && !done_ok));

    a_r10_none_op: assert property (@(posedge clk) disable iff (rst)
        (cmd_start && !busy && cmd_op == 2'd3) |=> (!busy && !done));

endmodule

bind flash_row_seq flash_row_seq_chk #(.AW(AW), .PAGE_LG(flash_seq_pkg::PAGE_LG)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_start(cmd_start),
    .cmd_op   (cmd_op),
    .arr_wr   (arr_wr),
    .arr_erase(arr_erase),
    .arr_addr (arr_addr),
    .busy     (busy),
    .done     (done),
    .done_ok  (done_ok),
    .load_err (load_err)
);

// File: tb/test_flash_row_seq.sv
module test_flash_row_seq;
    import flash_seq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int AW       = 12;
    localparam int ROW_CYC  = 100;
    localparam int WORD_CYC = 9;
    localparam int PAGE_CYC = 150;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tw_we = 1'b0;
    logic [AW-1:0] tw_addr = '0;
    logic [23:0]   tw_data = '0;
    logic          cmd_start = 1'b0;
    logic [1:0]    cmd_op = 2'd3;
    logic [AW-1:0] cmd_addr = '0;
    logic          rc_tick = 1'b0;
    logic          arr_wr, arr_erase, busy, done, done_ok, load_err;
    logic [AW-1:0] arr_addr;
    logic [23:0]   arr_wdata;

    int n_checks = 0;
    int n_fail   = 0;
    int tphase   = 0;

    typedef struct {
        bit    er;
        int    addr;
        int    data;
        string req;
    } exp_t;
    exp_t exp_q[$];
    logic [23:0] model [0:(1<<AW)-1];

    flash_row_seq #(
        .AW(AW), .ROW_CYC(ROW_CYC), .WORD_CYC(WORD_CYC), .PAGE_CYC(PAGE_CYC)
    ) i_flash_row_seq (
        .clk(clk), .rst(rst), .tw_we(tw_we), .tw_addr(tw_addr), .tw_data(tw_data),
        .cmd_start(cmd_start), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .rc_tick(rc_tick),
        .arr_wr(arr_wr), .arr_erase(arr_erase), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .busy(busy), .done(done), .done_ok(done_ok), .load_err(load_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // RC enable: one tick every third clock, changed away from the edge.
    always @(posedge clk) begin
        #2;
        tphase  = (tphase + 1) % 3;
        rc_tick = (tphase == 0);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] pat(input int a, input int i);
        return {8'(i) ^ 8'h5A, 16'(a)};
    endfunction

    // Monitor: pops the expected array operation and updates the array model.
    always @(negedge clk) begin
        if (!rst && (arr_wr || arr_erase)) begin
            if (exp_q.size() == 0) begin
                check(0, "R10", "unexpected array op at", longint'(arr_addr), 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(arr_erase == e.er, e.req, "op kind", longint'(arr_erase), longint'(e.er));
                check(int'(arr_addr) == e.addr, e.req, "array addr", longint'(arr_addr), longint'(e.addr));
                if (!e.er)
                    check(int'(arr_wdata) == e.data, e.req, "array data", longint'(arr_wdata), longint'(e.data));
            end
            if (arr_erase) begin
                for (int k = 0; k < 512; k++) model[int'(arr_addr) + k] = 24'hFFFFFF;
            end else begin
                model[arr_addr] = arr_wdata;
            end
        end
    end

    task automatic load(input int a, input logic [23:0] d);
        @(negedge clk);
        tw_we = 1'b1; tw_addr = AW'(a); tw_data = d;
        @(negedge clk);
        tw_we = 1'b0;
    endtask

    task automatic load_row(input int base);
        for (int i = 0; i < 64; i++) load(base + i, pat(base + i, i));
    endtask

    task automatic push_row(input int base);
        for (int i = 0; i < 64; i++) exp_q.push_back('{0, base + i, int'(pat(base + i, i)), "R4"});
    endtask

    task automatic run_op(input flash_op_e op, input int a, input bit exp_ok,
                          input int exp_ticks, input string req);
        int cnt = 0;
        int guard = 0;
        @(negedge clk);
        cmd_start = 1'b1; cmd_op = op; cmd_addr = AW'(a);
        @(negedge clk);
        cmd_start = 1'b0;
        if (!exp_ok) begin
            check(done && !done_ok && !busy, req, "refusal done/ok/busy",
                  {done, done_ok, busy}, 3'b100);
        end else begin
            check(busy, req, "busy after start", busy, 1);
            while (busy && guard < 5000) begin
                if (rc_tick) cnt++;
                guard++;
                @(negedge clk);
            end
            check(done && done_ok, "R8", "done pulse on busy fall", {done, done_ok}, 2'b11);
            check(cnt == exp_ticks, "R8", "busy rc ticks", cnt, exp_ticks);
            @(negedge clk);
            check(!done, "R8", "done single cycle", done, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "WDOG", "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < (1 << AW); k++) model[k] = 24'h0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!busy && !done && !load_err && !arr_wr && !arr_erase, "R1", "reset outputs",
              {busy, done, load_err, arr_wr, arr_erase}, 0);

        // R6 page erase with unaligned address
        exp_q.push_back('{1, 'h200, 0, "R6"});
        run_op(OP_PAGE, 'h25F, 1, PAGE_CYC, "R6");

        // R2, R4, R8 full row load and program; R3/R10 injection while busy
        load_row('h240);
        check(!load_err, "R2", "in-order row load error", load_err, 0);
        push_row('h240);
        fork
            run_op(OP_ROW, 0, 1, ROW_CYC, "R4");
            begin
                repeat (20) @(negedge clk);
                cmd_start = 1'b1; cmd_op = OP_PAGE; cmd_addr = '0;
                tw_we = 1'b1; tw_addr = 'h777; tw_data = 24'h123456;
                @(negedge clk);
                cmd_start = 1'b0; tw_we = 1'b0;
            end
        join
        check(!load_err, "R3", "load while busy left error", load_err, 0);

        // R9 buffer restarts at zero with a new group
        load_row('h080);
        check(!load_err, "R9", "new group after row program", load_err, 0);
        push_row('h080);
        run_op(OP_ROW, 0, 1, ROW_CYC, "R9");

        // R10 no-op command
        @(negedge clk);
        cmd_start = 1'b1; cmd_op = OP_NONE;
        @(negedge clk);
        cmd_start = 1'b0;
        check(!busy && !done, "R10", "none op busy/done", {busy, done}, 0);

        // R7 word program uses buffer slot 0
        load('h300, 24'h13579B);
        exp_q.push_back('{0, 'h123, 'h13579B, "R7"});
        run_op(OP_WORD, 'h123, 1, WORD_CYC, "R7");

        // R2 out-of-order load sets sticky error; R5 refusal clears it
        load('h305, 24'h1);
        check(load_err, "R2", "skip load error", load_err, 1);
        load('h301, 24'h2);
        check(load_err, "R2", "error sticky", load_err, 1);
        run_op(OP_ROW, 0, 0, 0, "R5");
        check(!load_err, "R5", "error cleared by refusal", load_err, 0);

        // R2 misaligned first load
        load('h105, 24'h3);
        check(load_err, "R2", "misaligned first load", load_err, 1);
        run_op(OP_ROW, 0, 0, 0, "R5");

        // R5 partial buffer refused
        load('h400, 24'h4);
        check(!load_err, "R2", "aligned first load", load_err, 0);
        run_op(OP_ROW, 0, 0, 0, "R5");

        // R2 65th load overflows
        load_row('h500);
        check(!load_err, "R2", "full row no error", load_err, 0);
        load('h540, 24'h5);
        check(load_err, "R2", "65th load error", load_err, 1);
        run_op(OP_ROW, 0, 0, 0, "R5");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R4", "pending array ops", exp_q.size(), 0);
        check(model['h240] == pat('h240, 0) && model['h27F] == pat('h27F, 63), "R4",
              "array row 0x240 ends", model['h27F], pat('h27F, 63));
        check(model['h0BF] == pat('h0BF, 63), "R9", "array row 0x080 end", model['h0BF], pat('h0BF, 63));
        check(model['h200] == 24'hFFFFFF && model['h3FF] == 24'hFFFFFF, "R6", "erased page",
              model['h3FF], 24'hFFFFFF);
        check(model['h123] == 24'h13579B, "R7", "word in array", model['h123], 24'h13579B);
        check(model['h000] == 24'h0 && model['h777] == 24'h0, "R10", "ignored start left array",
              model['h000], 0);
        check(model['h500] == 24'h0, "R5", "refused row not written", model['h500], 0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule